// File: doc/BRIEF.md
# External Interrupt Trigger Configurator

This block conditions a small group of asynchronous interrupt pins before they reach an interrupt aggregator or a processor input. Every pin is brought into the clock domain by a synchroniser. It is then qualified by its own trigger mode: active-low level, active-high level, rising edge, falling edge or any edge. The block drives one request line per pin. That line is gated by the pin's enable bit.

Edge-qualified events are held in a sticky latch per pin until software acknowledges them by writing a one to the pin's clear bit. Level-qualified pins pass the live, synchronised level with no storage. Configuration is held in 32-bit words. Each word covers four pins, one byte per pin. A single write updates the mode, the enable and the acknowledge of all four pins in that word.

Top module: `xirq_trigger_top`

## Requirements
- R1: After reset, every present pin is set to active-low level with its enable cleared, and every irqReq bit is 0. With all pins held low, each present pin byte reads 0x28.
- R2: Word w (cfgSel = w) covers pins 4w to 4w+3. Pin p occupies byte (p mod 4), bits [8k+7:8k]. Within that byte, bit 0 is enable, bit 1 is clear (write-only), bit 2 is sense, bit 3 is level-select and bit 4 is any-edge. Bit 5 reads the pin's pending state and bits 6 and 7 read 0.
- R3: With level-select=1 and sense=1, irqReq follows the pin high. A pin change shows on irqReq after the second rising clock edge that follows it.
- R4: With level-select=1 and sense=0, irqReq follows the pin low, with the same two-edge latency as R3.
- R5: With level-select=0 and sense=1, a rising pin transition sets the pin's latch, and irqReq rises after the third clock edge that follows the transition. The latch holds through later pin changes until it is cleared.
- R6: With level-select=0 and sense=0, only a falling pin transition sets the latch. A rising transition leaves it clear.
- R7: With any-edge=1, both transitions set the latch, whatever the level-select and sense bits hold.
- R8: With enable=0, irqReq for that pin stays 0, but the latch still records events and shows in the pending bit. Setting enable later raises irqReq from the held latch on the edge that takes the write.
- R9: Writing a 1 to a pin's clear bit empties its latch on the edge that takes the write. The clear bit always reads as 0.
- R10: When a clear and a new qualifying edge arrive on the same clock edge, the latch stays set.
- R11: A write with cfgSel selecting a word with no present pins is ignored, and such a word reads 0. Bytes for pin slots at or above NUM_PINS ignore writes and read 0.
- R12: While a pin is in a level mode its latch is emptied. A latch that was set before the pin moved into a level mode is gone when the pin returns to an edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Write strobe for the selected configuration word |
| cfgSel | input | SEL_W | Configuration word select, used for both write and read |
| cfgWdata | input | 32 | Write data: four pin bytes |
| cfgRdata | output | 32 | Read data of the selected word (combinational) |
| extPin | input | NUM_PINS | Asynchronous external interrupt pins |
| irqReq | output | NUM_PINS | Conditioned, enabled request per pin |

## Verification
The hardest case to reach is the race between an acknowledge and a fresh edge on the same clock edge. The edge event exists for only one cycle, two synchroniser edges after the pin moves. The stimulus raises a pin, counts exactly two clock edges and then issues the clear write, so that the write lands on the edge where the latch sets. A second hard case is a latch that is dropped by a brief detour through a level mode. The bench sets a latch, writes a level mode, and on the very next cycle writes the edge mode back. The level mode is therefore held for exactly one clock edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int PINS_PER_REG = 4;
  localparam int SLOT_W       = 8;
  localparam int REG_W        = PINS_PER_REG * SLOT_W;

  // bit positions inside one pin byte
  localparam int B_EN   = 0;
  localparam int B_CLR  = 1;
  localparam int B_SNS  = 2;
  localparam int B_LVL  = 3;
  localparam int B_BOTH = 4;
  localparam int B_PEND = 5;

  typedef struct packed {
    logic bothEdge;
    logic levelSel;
    logic sense;
    logic enable;
  } pinCfg_t;

  // strobes from control to datapath, one per pin
  typedef struct packed {
    logic load;
    logic clr;
  } pinStrb_t;

  typedef enum logic [2:0] {
    TRIG_LVL_LOW,
    TRIG_LVL_HIGH,
    TRIG_FALL,
    TRIG_RISE,
    TRIG_BOTH
  } trigMode_e;

  localparam pinCfg_t CFG_RESET = '{bothEdge: 1'b0, levelSel: 1'b1, sense: 1'b0, enable: 1'b0};

  function automatic trigMode_e decodeMode(pinCfg_t c);
    if (c.bothEdge)      return TRIG_BOTH;
    else if (c.levelSel) return c.sense ? TRIG_LVL_HIGH : TRIG_LVL_LOW;
    else                 return c.sense ? TRIG_RISE : TRIG_FALL;
  endfunction

  function automatic logic isLevelMode(pinCfg_t c);
    return c.levelSel && !c.bothEdge;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int SEL_W    = 2
) (
  input  logic                      cfgWe,
  input  logic [SEL_W-1:0]          cfgSel,
  input  logic [REG_W-1:0]          cfgWdata,
  output logic [REG_W-1:0]          cfgRdata,
  output pinStrb_t [NUM_PINS-1:0]   strb,
  output pinCfg_t  [NUM_PINS-1:0]   newCfg,
  input  pinCfg_t  [NUM_PINS-1:0]   curCfg,
  input  logic     [NUM_PINS-1:0]   pendQ
);

  localparam int NUM_REGS = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG;

  function automatic logic [REG_W-1:0] usedMask();
    logic [REG_W-1:0] m = '0;
    for (int k = 0; k < PINS_PER_REG; k++) begin
      m[k*SLOT_W + B_EN]   = 1'b1;
      m[k*SLOT_W + B_CLR]  = 1'b1;
      m[k*SLOT_W + B_SNS]  = 1'b1;
      m[k*SLOT_W + B_LVL]  = 1'b1;
      m[k*SLOT_W + B_BOTH] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] USED_BITS = usedMask();

  // write decode: one load/clear strobe pair per pin
  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_dec
      localparam int REG_IDX = p / PINS_PER_REG;
      localparam int SLOT    = p % PINS_PER_REG;
      logic [SLOT_W-1:0] slotData;
      logic              regHit;

      assign slotData        = cfgWdata[SLOT*SLOT_W +: SLOT_W];
      assign regHit          = cfgWe && (cfgSel == SEL_W'(REG_IDX));
      assign strb[p].load    = regHit;
      assign strb[p].clr     = regHit && slotData[B_CLR];
      assign newCfg[p].bothEdge = slotData[B_BOTH];
      assign newCfg[p].levelSel = slotData[B_LVL];
      assign newCfg[p].sense    = slotData[B_SNS];
      assign newCfg[p].enable   = slotData[B_EN];
    end
  endgenerate

  // bits of the write word that no pin consumes
  logic unusedWr;
  assign unusedWr = ^(cfgWdata & ~USED_BITS);

  // read mux: clear bit and spare bits always read zero
  always_comb begin
    cfgRdata = '0;
    for (int q = 0; q < NUM_PINS; q++) begin
      if (cfgSel == SEL_W'(q / PINS_PER_REG)) begin
        cfgRdata[(q % PINS_PER_REG)*SLOT_W +: SLOT_W] =
          {2'b00, pendQ[q], curCfg[q].bothEdge, curCfg[q].levelSel,
           curCfg[q].sense, 1'b0, curCfg[q].enable};
      end
    end
    if (32'(cfgSel) >= NUM_REGS) cfgRdata = '0;
  end

endmodule

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic     [NUM_PINS-1:0] extPin,
  input  pinStrb_t [NUM_PINS-1:0] strb,
  input  pinCfg_t  [NUM_PINS-1:0] newCfg,
  output pinCfg_t  [NUM_PINS-1:0] curCfg,
  output logic     [NUM_PINS-1:0] pendQ,
  output logic     [NUM_PINS-1:0] irqReq
);

  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] pinPrev;

  xirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (extPin),
    .syncOut (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      pinCfg_t   cfgQ;
      trigMode_e mode;
      logic      riseEvt, fallEvt, edgeEvt, liveHit, latchQ, lvlMode;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             cfgQ <= CFG_RESET;
        else if (strb[p].load) cfgQ <= newCfg[p];
      end

      assign riseEvt = pinSync[p] & ~pinPrev[p];
      assign fallEvt = ~pinSync[p] & pinPrev[p];

      always_comb begin
        mode    = decodeMode(cfgQ);
        lvlMode = (mode == TRIG_LVL_LOW) || (mode == TRIG_LVL_HIGH);
        unique case (mode)
          TRIG_RISE: edgeEvt = riseEvt;
          TRIG_FALL: edgeEvt = fallEvt;
          TRIG_BOTH: edgeEvt = riseEvt | fallEvt;
          default:   edgeEvt = 1'b0;
        endcase
        liveHit = (pinSync[p] == cfgQ.sense);
      end

      // new event outranks a same-cycle clear
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        latchQ <= 1'b0;
        else if (lvlMode) latchQ <= 1'b0;
        else              latchQ <= (latchQ & ~strb[p].clr) | edgeEvt;
      end

      assign curCfg[p] = cfgQ;
      assign pendQ[p]  = lvlMode ? liveHit : latchQ;
      assign irqReq[p] = cfgQ.enable & pendQ[p];
    end
  endgenerate

endmodule

// File: rtl/xirq_trigger_top.sv
module xirq_trigger_top
  import xirq_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [31:0]         cfgWdata,
  output logic [31:0]         cfgRdata,
  input  logic [NUM_PINS-1:0] extPin,
  output logic [NUM_PINS-1:0] irqReq
);

  pinStrb_t [NUM_PINS-1:0] strb;
  pinCfg_t  [NUM_PINS-1:0] newCfg;
  pinCfg_t  [NUM_PINS-1:0] curCfg;
  logic     [NUM_PINS-1:0] pendQ;

  xirq_ctrl #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_ctrl (
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .strb     (strb),
    .newCfg   (newCfg),
    .curCfg   (curCfg),
    .pendQ    (pendQ)
  );

  xirq_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .extPin (extPin),
    .strb   (strb),
    .newCfg (newCfg),
    .curCfg (curCfg),
    .pendQ  (pendQ),
    .irqReq (irqReq)
  );

endmodule

// File: rtl/xirq_checker.sv
module xirq_checker
  import xirq_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int SEL_W    = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [SEL_W-1:0]        cfgSel,
  input logic [31:0]             cfgRdata,
  input pinCfg_t  [NUM_PINS-1:0] curCfg,
  input pinCfg_t  [NUM_PINS-1:0] newCfg,
  input pinStrb_t [NUM_PINS-1:0] strb,
  input logic     [NUM_PINS-1:0] pendQ,
  input logic     [NUM_PINS-1:0] irqReq
);

  localparam int NUM_REGS = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG;

  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_chk
      p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
        !curCfg[i].enable |-> !irqReq[i]);

      p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
        (!isLevelMode(curCfg[i]) && pendQ[i] && !strb[i].load) |=> pendQ[i]);

      p_level_drops_latch_r12: assert property (@(posedge clk) disable iff (!rstN)
        (isLevelMode(curCfg[i]) && strb[i].load && !isLevelMode(newCfg[i])) |=> !pendQ[i]);
    end
  endgenerate

  p_unmapped_read_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (32'(cfgSel) >= NUM_REGS) |-> (cfgRdata == 32'h0));

endmodule

bind xirq_trigger_top xirq_checker #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgSel   (cfgSel),
  .cfgRdata (cfgRdata),
  .curCfg   (curCfg),
  .newCfg   (newCfg),
  .strb     (strb),
  .pendQ    (pendQ),
  .irqReq   (irqReq)
);

// File: tb/sim_xirq_trigger_top.sv
`timescale 1ns/1ps
module sim_xirq_trigger_top;

  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [31:0]   cfgWdata = '0;
  logic [31:0]   cfgRdata;
  logic [NP-1:0] extPin = '0;
  logic [NP-1:0] irqReq;

  xirq_trigger_top #(.NUM_PINS(NP), .SEL_W(2)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .extPin(extPin), .irqReq(irqReq)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int          due;
    bit          isRd;
    logic [31:0] mask;
    logic [31:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations just after their clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (expQ.size() > 0 && expQ[0].due <= cyc) begin
        expItem_t it;
        logic [31:0] act;
        it  = expQ.pop_front();
        act = it.isRd ? cfgRdata : 32'(irqReq);
        nChecks++;
        if (it.due < cyc) begin
          nFails++;
          $display("FAIL %s stale item due=%0d now=%0d actual=%h expected=%h",
                   it.tag, it.due, cyc, act & it.mask, it.val);
        end else if ((act & it.mask) !== it.val) begin
          nFails++;
          $display("FAIL %s cycle=%0d %s actual=%h expected=%h",
                   it.tag, cyc, it.isRd ? "rdata" : "irqReq", act & it.mask, it.val);
        end
      end
    end
  end

  task automatic expIrq(input int dly, input logic [31:0] m, input logic [31:0] v, input string tag);
    expItem_t it;
    it.due = cyc + dly; it.isRd = 1'b0; it.mask = m; it.val = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic expRd(input int dly, input logic [31:0] v, input string tag);
    expItem_t it;
    it.due = cyc + dly; it.isRd = 1'b1; it.mask = '1; it.val = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [31:0] data);
    cfgSel = sel; cfgWdata = data; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  logic [31:0] r0, r1;

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(3);

    // R1 reset state, R11 absent slots
    expRd(1, 32'h28282828, "R1");
    expIrq(1, 32'h3F, 32'h0, "R1");
    waitN(1);
    cfgSel = 2'd1;
    expRd(1, 32'h00002828, "R1");
    waitN(1);

    // R3 level high on pin0
    r0 = 32'h0808080D;
    expIrq(1, 32'h1, 32'h0, "R3");
    wrReg(0, r0);
    extPin[0] = 1'b1;
    expIrq(1, 32'h1, 32'h0, "R3");
    expIrq(2, 32'h1, 32'h1, "R3");
    waitN(3);
    extPin[0] = 1'b0;
    expIrq(1, 32'h1, 32'h1, "R3");
    expIrq(2, 32'h1, 32'h0, "R3");
    waitN(3);
    expRd(1, 32'h2828280D, "R2");
    waitN(1);

    // R4 level low on pin1
    r0 = 32'h0808090D;
    expIrq(1, 32'h2, 32'h2, "R4");
    wrReg(0, r0);
    extPin[1] = 1'b1;
    expIrq(1, 32'h2, 32'h2, "R4");
    expIrq(2, 32'h2, 32'h0, "R4");
    waitN(3);
    extPin[1] = 1'b0;
    expIrq(2, 32'h2, 32'h2, "R4");
    waitN(3);

    // R5 rising edge on pin2
    r0 = 32'h0805090D;
    expIrq(1, 32'h4, 32'h0, "R5");
    wrReg(0, r0);
    extPin[2] = 1'b1;
    expIrq(2, 32'h4, 32'h0, "R5");
    expIrq(3, 32'h4, 32'h4, "R5");
    waitN(4);
    extPin[2] = 1'b0;
    expIrq(3, 32'h4, 32'h4, "R5");
    waitN(4);
    expRd(1, 32'h2825290D, "R2");
    waitN(1);
    // R9 clear and clear bit reads zero
    expIrq(1, 32'h4, 32'h0, "R9");
    expRd(1, 32'h2805290D, "R9");
    wrReg(0, r0 | 32'h00020000);
    waitN(1);

    // R6 falling edge on pin3
    r0 = 32'h0105090D;
    wrReg(0, r0);
    extPin[3] = 1'b1;
    expIrq(3, 32'h8, 32'h0, "R6");
    waitN(4);
    extPin[3] = 1'b0;
    expIrq(2, 32'h8, 32'h0, "R6");
    expIrq(3, 32'h8, 32'h8, "R6");
    waitN(4);
    expIrq(1, 32'h8, 32'h0, "R9");
    wrReg(0, r0 | 32'h02000000);

    // R7 any edge on pin4 with level and sense also set
    r1 = 32'h0000081D;
    expIrq(1, 32'h10, 32'h0, "R7");
    wrReg(1, r1);
    extPin[4] = 1'b1;
    expIrq(2, 32'h10, 32'h0, "R7");
    expIrq(3, 32'h10, 32'h10, "R7");
    waitN(4);
    expIrq(1, 32'h10, 32'h0, "R9");
    wrReg(1, r1 | 32'h2);
    extPin[4] = 1'b0;
    expIrq(3, 32'h10, 32'h10, "R7");
    waitN(4);
    expIrq(1, 32'h10, 32'h0, "R9");
    wrReg(1, r1 | 32'h2);

    // R8 disabled rising pin5 records, enable releases
    r1 = 32'h0000041D;
    wrReg(1, r1);
    extPin[5] = 1'b1;
    expIrq(3, 32'h20, 32'h0, "R8");
    waitN(4);
    expRd(1, 32'h0000241D, "R8");
    waitN(1);
    r1 = 32'h0000051D;
    expIrq(1, 32'h20, 32'h20, "R8");
    wrReg(1, r1);
    expIrq(1, 32'h20, 32'h0, "R9");
    wrReg(1, r1 | 32'h200);

    // R10 clear on the same edge as a new rising event on pin2
    cfgSel = 2'd0;
    extPin[2] = 1'b1;
    waitN(2);
    expIrq(1, 32'h4, 32'h4, "R10");
    expIrq(2, 32'h4, 32'h4, "R10");
    wrReg(0, r0 | 32'h00020000);
    waitN(2);
    expIrq(1, 32'h4, 32'h0, "R10");
    wrReg(0, r0 | 32'h00020000);

    // R11 unmapped word and absent slots
    expIrq(1, 32'h3F, 32'h02, "R11");
    expRd(1, 32'h0, "R11");
    wrReg(2, 32'hFFFFFFFF);
    cfgSel = 2'd0;
    expRd(1, 32'h0105290D, "R11");
    waitN(1);
    expRd(1, 32'h0000051D, "R11");
    wrReg(1, 32'h1F1F051D);

    // R12 latch dropped by a one-edge level detour
    extPin[2] = 1'b0;
    waitN(3);
    extPin[2] = 1'b1;
    expIrq(3, 32'h4, 32'h4, "R12");
    waitN(4);
    expIrq(1, 32'h4, 32'h0, "R12");
    wrReg(0, 32'h0109090D);
    expIrq(1, 32'h4, 32'h0, "R12");
    expIrq(3, 32'h4, 32'h0, "R12");
    wrReg(0, r0);
    waitN(5);

    done = 1'b1;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R1 leftover expectations actual=%0d expected=0", expQ.size());
    end
    summary();
    $finish;
  end

endmodule